// File: doc/BRIEF.md
# Synchronous Byte-Write SRAM Front End

This block is a single-port synchronous static memory with registered inputs and a flow-through read path. The default size is 256 words of 36 bits, split into four 9-bit lanes. All control, address and write data inputs are sampled on the rising clock edge. On that edge the block decides whether the cycle is a deselect, a write of some set of lanes, or a read.

A read returns its word during the clock period that follows the sampling edge, with no further output register. The shared data bus is modelled as a write-data input, a read-data output and a drive flag. The drive flag is gated at once by the output enable pin. Burst address generation sits outside the block.

A global write strobe forces every lane to be written. Otherwise, a byte-write enable together with per-lane strobes writes any subset of the lanes. A cycle that writes no lane is a read.

Top module: `sbw_sram`

## Requirements
- R1: The block is selected on a sampled edge only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. On any other combination it writes nothing, and after that edge `bus_drive` is 0.
- R2: On a selected edge with `gwr_n`=0, all four lanes at `addr` take `wdata`, whatever `bwr_n` and `lane_n` hold.
- R3: On a selected edge with `gwr_n`=1 and `bwr_n`=0, lane i (bits 9i+8..9i) is written exactly when `lane_n[i]`=0. Every other lane of the word keeps its previous contents.
- R4: Any subset of one to four lanes can be written in one byte-write cycle.
- R5: With `gwr_n`=1 and `bwr_n`=1, `lane_n` has no effect: nothing is written and the cycle is a read.
- R6: With `gwr_n`=1, `bwr_n`=0 and `lane_n`=4'b1111, nothing is written and the cycle is a read.
- R7: A selected read sampled at edge k shows the word at `addr` on `rdata` in the period between edge k and edge k+1, with no added cycle.
- R8: `bus_drive` is 1 only when the last sampled edge was a selected read and `oe_n` is currently 0. `oe_n` acts without a clock edge, and `rdata` is all zero whenever `bus_drive` is 0.
- R9: Deselection takes effect in one cycle: a read followed by a deselected edge leaves `bus_drive` at 0 right after the second edge.
- R10: A read in the cycle right after a write to the same address returns the newly written lanes.
- R11: Synchronous active-high `rst` forces `bus_drive` to 0 after the edge it is sampled on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Word address |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low, not registered |
| wdata | input | LANES*LANE_W | Write data from the shared bus |
| rdata | output | LANES*LANE_W | Read data to the shared bus, zero when not driving |
| bus_drive | output | 1 | High when the block drives the shared bus |

## Verification
The bench first fills the whole array with global writes. It then goes after cases where the write decode could go wrong:
- a global write with every lane strobe inactive, which a design that lets lane strobes mask the global write would store only partly;
- lane strobes with the byte enable inactive, and the byte enable with no strobe, which a careless decode turns into writes or into dead cycles that never drive the bus.

A random mix of lane subsets then checks that unwritten lanes survive. It also covers the chip-enable combinations, where a one-bit decode error writes while deselected. Directed sequences check that deselection after a read drops the drive on the very next edge, that a write-then-read returns the fresh lanes and not stale ones, and that toggling `oe_n` mid-cycle changes the drive without waiting for a clock, which a registered enable would not do.

// File: rtl/sbw_pkg.sv
`timescale 1ns/1ps
package sbw_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } sbw_cyc_e;
endpackage

// File: rtl/sbw_ctl.sv
`timescale 1ns/1ps
// Decodes chip selection and the per-lane write mask from the raw pins.
module sbw_ctl
  import sbw_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] lane_we,
  output sbw_cyc_e         cyc
);
  logic             picked;
  logic [LANES-1:0] mask;

  always_comb begin
    picked = !en_a_n && en_b && !en_c_n;
    if (!gwr_n)      mask = '1;
    else if (!bwr_n) mask = ~lane_n;
    else             mask = '0;
    if (!picked)     cyc = CYC_IDLE;
    else if (|mask)  cyc = CYC_WRITE;
    else             cyc = CYC_READ;
    lane_we = (cyc == CYC_WRITE) ? mask : '0;
  end
endmodule

// File: rtl/sbw_lane_mem.sv
`timescale 1ns/1ps
// One lane of storage, written so that a block RAM can be inferred.
module sbw_lane_mem #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [LANE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= din;
    dout <= store[addr];
  end
endmodule

// File: rtl/sbw_sram.sv
`timescale 1ns/1ps
module sbw_sram
  import sbw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_a_n,
  input  logic                    en_b,
  input  logic                    en_c_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    gwr_n,
  input  logic                    bwr_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    bus_drive
);
  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0]  lane_we;
  sbw_cyc_e          cyc;
  logic [DATA_W-1:0] word_q;
  logic              rd_q;

  sbw_ctl #(.LANES(LANES)) u_ctl (
    .en_a_n (en_a_n),
    .en_b   (en_b),
    .en_c_n (en_c_n),
    .gwr_n  (gwr_n),
    .bwr_n  (bwr_n),
    .lane_n (lane_n),
    .lane_we(lane_we),
    .cyc    (cyc)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbw_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
      .clk (clk),
      .we  (lane_we[g]),
      .addr(addr),
      .din (wdata[g*LANE_W +: LANE_W]),
      .dout(word_q[g*LANE_W +: LANE_W])
    );
  end

  // Read flag for the period after the sampling edge.
  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= (cyc == CYC_READ);
  end

  always_comb begin
    bus_drive = rd_q && !oe_n;
    rdata     = bus_drive ? word_q : '0;
  end
endmodule

// File: rtl/sbw_sram_chk.sv
`timescale 1ns/1ps
module sbw_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en_a_n,
  input logic                    en_b,
  input logic                    en_c_n,
  input logic                    gwr_n,
  input logic                    bwr_n,
  input logic [LANES-1:0]        lane_n,
  input logic                    oe_n,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic                    bus_drive
);
  logic chosen, writes;
  assign chosen = !en_a_n && en_b && !en_c_n;
  assign writes = !gwr_n || (!bwr_n && !(&lane_n));

  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !chosen |=> !bus_drive);
  // R8
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (chosen && writes) |=> !bus_drive);
  // R7
  read_drives_chk: assert property (@(posedge clk) disable iff (rst)
    (chosen && !writes) |=> (bus_drive == !oe_n));
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_drive |-> (rdata == '0));
  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> !oe_n);
endmodule

bind sbw_sram sbw_sram_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
  .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n), .oe_n(oe_n),
  .rdata(rdata), .bus_drive(bus_drive)
);

// File: tb/sim_sbw_sram.sv
`timescale 1ns/1ps
module sim_sbw_sram;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam int NL = 4;
  localparam int DW = LW * NL;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_a_n = 1'b1, en_b = 1'b0, en_c_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic gwr_n = 1'b1, bwr_n = 1'b1, oe_n = 1'b1;
  logic [NL-1:0] lane_n = '1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic bus_drive;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [DW-1:0] mdl [DEPTH];

  always #4 clk = ~clk; // 125 MHz

  sbw_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u0 (
    .clk(clk), .rst(rst), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .addr(addr), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n), .oe_n(oe_n),
    .wdata(wdata), .rdata(rdata), .bus_drive(bus_drive)
  );

  function automatic logic [NL-1:0] exp_mask(logic g, logic b, logic [NL-1:0] l);
    if (!g) return '1;
    if (!b) return ~l;
    return '0;
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                         logic [NL-1:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < NL; i++)
      if (m[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  task automatic check(string tag, logic drv, logic [DW-1:0] dat,
                       logic edrv, logic [DW-1:0] edat);
    total++;
    if (drv !== edrv || dat !== edat) begin
      bad++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               tag, drv, dat, edrv, edat);
    end
  endtask

  task automatic op(logic sa, logic sb, logic sc, logic g, logic b,
                    logic [NL-1:0] l, logic o, logic [AW-1:0] a,
                    logic [DW-1:0] d, string tag);
    logic sel, wr, edrv;
    logic [NL-1:0] m;
    en_a_n = sa; en_b = sb; en_c_n = sc; gwr_n = g; bwr_n = b;
    lane_n = l; oe_n = o; addr = a; wdata = d;
    @(posedge clk); #2;
    sel  = !sa && sb && !sc;
    m    = exp_mask(g, b, l);
    wr   = sel && (m != '0);
    edrv = sel && !wr && !o;
    check(tag, bus_drive, rdata, edrv, edrv ? mdl[a] : '0);
    if (wr) mdl[a] = merge(mdl[a], d, m);
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return DW'({$urandom(), $urandom()});
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    // R11: reset holds the bus idle
    check("R11", bus_drive, rdata, 1'b0, '0);
    rst = 1'b0;
    // Fill every word with a global write; lane strobes inactive (R2)
    for (int i = 0; i < DEPTH; i++)
      op(0, 1, 0, 0, 1, 4'b1111, 1, AW'(i), rnd_word(), "R2");
    // R2: global write overrides byte controls, then read back
    op(0, 1, 0, 0, 0, 4'b0101, 1, 8'h10, 36'h123456789, "R2");
    op(0, 1, 0, 1, 1, 4'b1111, 0, 8'h10, '0, "R2");
    // R3: two lanes, then readback (R10 back-to-back)
    op(0, 1, 0, 1, 0, 4'b1010, 1, 8'h20, 36'hABCDEF012, "R3");
    op(0, 1, 0, 1, 1, 4'b1111, 0, 8'h20, '0, "R10");
    // R5: strobes without byte enable -> read, no store
    op(0, 1, 0, 1, 1, 4'b0000, 0, 8'h21, 36'hFFFFFFFFF, "R5");
    op(0, 1, 0, 1, 1, 4'b1111, 0, 8'h21, '0, "R5");
    // R6: byte enable without strobes -> read
    op(0, 1, 0, 1, 0, 4'b1111, 0, 8'h22, 36'h0F0F0F0F0, "R6");
    op(0, 1, 0, 1, 1, 4'b1111, 0, 8'h22, '0, "R6");
    // R9: read then deselect drops drive on the next edge
    op(0, 1, 0, 1, 1, 4'b1111, 0, 8'h30, '0, "R7");
    op(1, 1, 0, 1, 1, 4'b1111, 0, 8'h30, '0, "R9");
    // R1: deselected global write must not store
    op(0, 0, 0, 0, 1, 4'b1111, 0, 8'h31, 36'h111111111, "R1");
    op(0, 1, 1, 0, 1, 4'b1111, 0, 8'h31, 36'h222222222, "R1");
    op(0, 1, 0, 1, 1, 4'b1111, 0, 8'h31, '0, "R1");
    // R8: output enable acts within the cycle
    op(0, 1, 0, 1, 1, 4'b1111, 0, 8'h40, '0, "R8");
    oe_n = 1'b1; #1;
    check("R8", bus_drive, rdata, 1'b0, '0);
    oe_n = 1'b0; #1;
    check("R8", bus_drive, rdata, 1'b1, mdl[8'h40]);
    // Random mix: R4 lane subsets, R1 enables, R7 reads
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] en = 3'b010;
      logic g, b, o;
      logic [NL-1:0] l;
      logic [AW-1:0] a;
      string tag;
      if ($urandom_range(0, 7) == 0) en = 3'($urandom());
      g = ($urandom_range(0, 7) != 0);
      b = $urandom_range(0, 1) == 1;
      l = NL'($urandom());
      o = ($urandom_range(0, 5) == 0);
      a = AW'($urandom_range(0, 15));
      if (en != 3'b010)                tag = "R1";
      else if (!g)                     tag = "R2";
      else if (!b && l != '1)          tag = "R4";
      else                             tag = "R7";
      op(en[2], en[1], en[0], g, b, l, o, a, rnd_word(), tag);
    end
    // R11: reset mid-run clears drive
    op(0, 1, 0, 1, 1, 4'b1111, 0, 8'h05, '0, "R7");
    rst = 1'b1;
    @(posedge clk); #2;
    check("R11", bus_drive, rdata, 1'b0, '0);
    rst = 1'b0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: drive=%0b data=%h expected drive=0 data=0", bus_drive, rdata);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule